// File: doc/BRIEF.md
# IrDA SIR Pulse Stretching Decoder

This block turns the short infrared pulses of a serial-infrared link back into the plain serial level that a UART receiver expects. The receive line of the optical front end rests high. Each time it falls, one pulse has arrived, and that pulse stands for a zero bit. The block answers by pulling its serial output low for one full bit time. A bit time is a fixed number of ticks of a 16x-baud enable strobe, 16 by default. When no pulse is being stretched, the output rests high, which is a mark.

A falling edge that arrives while a stretch is in progress starts the bit-time count again. A row of zero bits, whose pulses come exactly one bit time apart, therefore gives one unbroken low level lasting one bit time per pulse. The receive input is first passed through a chain of synchroniser flip-flops, so it may come from any clock domain. An active-low reset clears the block and holds the output at idle. Pulses that fall while the reset is asserted are lost.

Top module: `sir_pulse_stretcher`

## Requirements
- R1: A falling edge on `ir_rx` drives `ser_out` low at the third rising `clk` edge after the input change: two synchroniser stages, then one edge/counter register.
- R2: Once a stretch starts, `ser_out` stays low for exactly BIT_TICKS (16) `tick16` strobes that follow the start edge, and then returns high. With `tick16` high in every cycle, the low level lasts 16 clock cycles. With `tick16` high one cycle in four, it lasts 61 to 64 cycles.
- R3: A stretched low level never lasts fewer than 12 `tick16` strobes, which is three quarters of a bit time.
- R4: A falling edge that arrives during an active stretch reloads the full bit-time count. An edge 8 ticks into a stretch gives a low level of 8 + 16 = 24 ticks.
- R5: Pulses whose falling edges are one bit time apart give one continuous low level of 16 ticks per pulse. Three such pulses give 48 ticks.
- R6: A receive pulse only 3 clock cycles low is detected and stretched to the full bit time.
- R7: Only a high-to-low transition starts a stretch. An input held low for longer than a bit time gives a single 16-tick low level, and its return to high starts nothing.
- R8: The stretch count advances only on cycles where `tick16` is high. Without strobes, `ser_out` stays low.
- R9: While `rst_n` is low, `ser_out` is high, and that holds even if a stretch was under way. Falling edges during reset cause no stretch after release, provided `ir_rx` is high at release.
- R10: After reset and between stretches, `ser_out` idles high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; blocks reception while low |
| tick16 | input | 1 | One-cycle enable strobe at 16 times the baud rate |
| ir_rx | input | 1 | Receive line from the optical front end, idles high, falls once per pulse |
| ser_out | output | 1 | Stretched serial level toward a UART receiver, idles high |

## Verification
A corrupted stretch counter shows up on `ser_out` in two ways. The low level is cut short, which breaks R3. Or it runs past the expected tick boundary, and a reload that is missed or extra lengthens a merged low run by a whole bit time. All of this is visible within one bit time of the fault. A broken synchroniser or edge register moves the start of the low level away from the third clock edge, or produces a stretch on a rising input. The directed scenarios measure latency and low-run length in clock cycles, so a one-cycle slip is caught in the scenario that exposes it.

// File: rtl/sir_dec_pkg.sv
package sir_dec_pkg;

    // Default number of 16x strobes in one bit time.
    localparam int unsigned DEF_BIT_TICKS   = 16;
    // Default shortest low level a UART accepts (three quarters of a bit).
    localparam int unsigned DEF_MIN_LOW     = 12;
    // Default depth of the input synchroniser.
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic {
        STR_IDLE    = 1'b0,
        STR_ACTIVE  = 1'b1
    } stretch_state_e;

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sir_fall_det.sv
module sir_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);

    typedef struct packed {
        logic prev;
    } det_t;

    det_t det_d;
    det_t det_q;

    always_comb begin
        det_d      = det_q;
        det_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '{prev: 1'b1};
        end else begin
            det_q <= det_d;
        end
    end

    // A previously high level seen low now marks one arriving pulse.
    assign fall = det_q.prev & ~lvl;

endmodule

// File: rtl/sir_stretch_ctr.sv
module sir_stretch_ctr
    import sir_dec_pkg::*;
#(
    parameter int unsigned BIT_TICKS = DEF_BIT_TICKS,
    localparam int unsigned CNT_W    = $clog2(BIT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    output logic [CNT_W-1:0] cnt,
    output logic             line
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BIT_TICKS);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        stretch_state_e   state;
        logic [CNT_W-1:0] cnt;
        logic             line;
    } ctr_t;

    ctr_t ctr_d;
    ctr_t ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (start) begin
            // Retrigger: any new edge restarts the full bit time.
            ctr_d.state = STR_ACTIVE;
            ctr_d.cnt   = LOAD_VAL;
        end else if (ctr_q.state == STR_ACTIVE && tick) begin
            if (ctr_q.cnt == ONE) begin
                ctr_d.state = STR_IDLE;
                ctr_d.cnt   = '0;
            end else begin
                ctr_d.cnt   = ctr_q.cnt - ONE;
            end
        end
        ctr_d.line = (ctr_d.state == STR_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{state: STR_IDLE, cnt: '0, line: 1'b1};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt  = ctr_q.cnt;
    assign line = ctr_q.line;

endmodule

// File: rtl/sir_pulse_stretcher.sv
module sir_pulse_stretcher
    import sir_dec_pkg::*;
#(
    parameter int unsigned BIT_TICKS   = DEF_BIT_TICKS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int unsigned CNT_W      = $clog2(BIT_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic ir_rx,
    output logic ser_out
);

    logic             ir_sync;
    logic             fall_evt;
    logic [CNT_W-1:0] stretch_cnt;

    sir_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ir_rx),
        .q     (ir_sync)
    );

    sir_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ir_sync),
        .fall  (fall_evt)
    );

    sir_stretch_ctr #(
        .BIT_TICKS (BIT_TICKS)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .start (fall_evt),
        .cnt   (stretch_cnt),
        .line  (ser_out)
    );

endmodule

// File: rtl/sir_pulse_stretcher_chk.sv
module sir_pulse_stretcher_chk
    import sir_dec_pkg::*;
#(
    parameter int unsigned BIT_TICKS = DEF_BIT_TICKS,
    parameter int unsigned MIN_LOW   = DEF_MIN_LOW,
    localparam int unsigned CNT_W    = $clog2(BIT_TICKS + 1),
    localparam int unsigned LT_W     = $clog2(MIN_LOW + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             fall,
    input logic [CNT_W-1:0] cnt,
    input logic             ser_out
);

    logic            armed_q;
    logic [LT_W-1:0] low_ticks_q;

    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
    end

    // Saturating count of strobes seen while the output is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_ticks_q <= '0;
        end else if (ser_out) begin
            low_ticks_q <= '0;
        end else if (tick && (low_ticks_q < LT_W'(MIN_LOW))) begin
            low_ticks_q <= low_ticks_q + LT_W'(1);
        end
    end

    assert_fall_drives_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !ser_out);

    assert_tick_steps_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && tick && !fall) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

    assert_min_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_out) |-> (low_ticks_q >= LT_W'(MIN_LOW)));

    assert_fall_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (cnt == CNT_W'(BIT_TICKS)));

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !fall) |=> $stable(cnt));

    assert_reset_idle_R9: assert property (@(posedge clk)
        (armed_q && !rst_n) |-> ser_out);

    assert_idle_stays_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !fall) |=> ser_out);

endmodule

bind sir_pulse_stretcher sir_pulse_stretcher_chk #(
    .BIT_TICKS (BIT_TICKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .fall    (fall_evt),
    .cnt     (stretch_cnt),
    .ser_out (ser_out)
);

// File: tb/sir_pulse_stretcher_bench.sv
`timescale 1ns/1ps
module sir_pulse_stretcher_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic tick16;
    logic ir_rx;
    logic ser_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  tick_period = 1;
    bit  tick_en = 1'b1;
    int  tick_ctr = 0;
    bit  reported = 1'b0;

    always #5 clk = ~clk;

    sir_pulse_stretcher u_sir_pulse_stretcher (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick16  (tick16),
        .ir_rx   (ir_rx),
        .ser_out (ser_out)
    );

    // 16x strobe source, updated away from the active edge.
    initial begin
        tick16 = 1'b0;
        forever begin
            @(negedge clk);
            if (!tick_en) begin
                tick16 = 1'b0;
            end else begin
                tick_ctr++;
                if (tick_ctr >= tick_period) begin
                    tick_ctr = 0;
                    tick16   = 1'b1;
                end else begin
                    tick16 = 1'b0;
                end
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Called at the negedge where ir_rx falls; returns latency and low width in cycles.
    task automatic measure(output int lat, output int width);
        lat = 0;
        width = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            lat++;
            if (!ser_out) break;
        end
        if (!ser_out) begin
            width = 1;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (ser_out) break;
                width++;
            end
        end
    endtask

    task automatic pulse(input int low_cycles);
        ir_rx = 1'b0;
        repeat (low_cycles) @(negedge clk);
        ir_rx = 1'b1;
    endtask

    task automatic count_lows(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!ser_out) lows++;
        end
    endtask

    task automatic t_reset_state();
        int lows;
        check(ser_out === 1'b1, "R9 output high after reset", int'(ser_out), 1);
        count_lows(20, lows);
        check(lows == 0, "R10 idle high with no pulses", lows, 0);
    endtask

    task automatic t_single_pulse();
        int lat, width;
        @(negedge clk);
        fork
            pulse(3);
            measure(lat, width);
        join
        check(lat == 3, "R1 latency to low", lat, 3);
        check(width == 16, "R2 low width one bit time", width, 16);
        check(width == 16, "R6 3-cycle pulse stretched", width, 16);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_retrigger();
        int lat, width;
        @(negedge clk);
        fork
            begin
                pulse(3);
                repeat (5) @(negedge clk);
                pulse(3);
            end
            measure(lat, width);
        join
        check(width == 24, "R4 retrigger reloads count", width, 24);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        int lat, width;
        @(negedge clk);
        fork
            begin
                for (int p = 0; p < 3; p++) begin
                    pulse(3);
                    repeat (13) @(negedge clk);
                end
            end
            measure(lat, width);
        join
        check(width == 48, "R5 three pulses merge", width, 48);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_held_low();
        int lat, width, lows;
        @(negedge clk);
        fork
            pulse(40);
            measure(lat, width);
        join
        check(width == 16, "R7 held-low input gives one stretch", width, 16);
        count_lows(25, lows);
        check(lows == 0, "R7 rising edge starts nothing", lows, 0);
    endtask

    task automatic t_slow_tick();
        int lat, width;
        tick_period = 4;
        tick_ctr = 0;
        @(negedge clk);
        fork
            pulse(3);
            measure(lat, width);
        join
        check(width >= 61 && width <= 64, "R2 width with quarter-rate strobe", width, 64);
        check(width >= 48, "R3 low at least 12 ticks", width, 48);
        repeat (8) @(negedge clk);
        tick_period = 1;
        tick_ctr = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_no_tick();
        int lows, lat;
        @(negedge clk);
        tick_en = 1'b0;
        pulse(3);
        count_lows(40, lows);
        check(lows == 40, "R8 count frozen without strobe", lows, 40);
        tick_en = 1'b1;
        lat = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            lat++;
            if (ser_out) break;
        end
        check(ser_out === 1'b1 && lat <= 17, "R8 resumes when strobe returns", lat, 16);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_mid();
        int lows;
        @(negedge clk);
        pulse(3);
        repeat (3) @(negedge clk);
        check(ser_out === 1'b0, "R9 stretch under way before reset", int'(ser_out), 0);
        rst_n = 1'b0;
        #1;
        check(ser_out === 1'b1, "R9 reset forces high", int'(ser_out), 1);
        @(negedge clk);
        pulse(3);
        repeat (4) @(negedge clk);
        check(ser_out === 1'b1, "R9 high while reset held", int'(ser_out), 1);
        rst_n = 1'b1;
        count_lows(25, lows);
        check(lows == 0, "R9 pulse in reset ignored", lows, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ir_rx = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single_pulse();
        t_retrigger();
        t_back_to_back();
        t_held_low();
        t_slow_tick();
        t_no_tick();
        t_reset_mid();
        report();
        $finish;
    end

endmodule